// File: doc/BRIEF.md
# Refresh Request Scheduler

This block keeps a DRAM controller current on its auto-refresh obligation. A free-running interval timer counts clocks up to the average refresh period and, on each wrap, adds one to a count of owed refreshes. While refreshes are owed, no refresh cycle is in flight and every bank reports precharged, the block raises a request toward the command arbiter. When the arbiter issues the refresh command it pulses the grant. The block then retires one owed refresh and holds a busy window for the refresh cycle time.

Refreshes may be postponed. The owed count saturates at eight, and an urgent flag tells the arbiter to stop deferring. A period boundary that arrives while eight are already owed sets a sticky overflow flag, because that refresh is lost. At 125 MHz a 7.8 us period is 975 clocks, and a 75 ns refresh cycle rounds up to 10 clocks.

Top module: `refresh_scheduler`

## Requirements
- R1: While rst_ni is low, and right after it is released, pending_o is 0 and req_o, urgent_o, busy_o and overflow_o are all 0.
- R2: The interval timer runs without stopping from reset. At the end of every INTERVAL_CLKS clocks it adds one to pending_o, so the first increment is visible after the INTERVAL_CLKS-th rising edge after reset release. Grants and bank state do not change the timer.
- R3: pending_o never goes above MAX_POSTED (8). urgent_o is high exactly when pending_o equals MAX_POSTED.
- R4: When an interval ends with pending_o at MAX_POSTED and no grant is accepted in that cycle, overflow_o goes high and pending_o stays at MAX_POSTED. overflow_o then stays high until reset.
- R5: req_o is high exactly when pending_o is nonzero, busy_o is low and banks_idle_i is high.
- R6: A grant is accepted when grant_i is high while req_o is high. An accepted grant lowers pending_o by one, unless R8 applies. busy_o is then high for exactly TRFC_CLKS cycles after that clock edge.
- R7: A grant_i pulse while req_o is low is ignored. It changes neither pending_o nor busy_o.
- R8: If an interval ends in the same cycle as an accepted grant, pending_o is unchanged. The busy window still starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Pulse: the arbiter has issued the refresh command |
| banks_idle_i | input | 1 | All banks are precharged |
| req_o | output | 1 | Refresh request to the arbiter |
| urgent_o | output | 1 | The maximum number of refreshes is postponed |
| busy_o | output | 1 | A refresh cycle is in progress |
| overflow_o | output | 1 | Sticky: a refresh interval was lost |
| pending_o | output | PEND_W (4) | Number of owed refreshes |

## Verification
The assertions assume that grant_i is a synchronous level that is stable around the clock edge. They also assume that the arbiter issues nothing else against a granted refresh, so the window after a grant reflects only this block. The stimulus changes grant_i and banks_idle_i one time unit after each rising edge. It drives grants both while a request is up and while it is down, so rejected grants are exercised. It also times one grant onto the exact cycle where an interval ends. A reference model in the bench predicts every output for each cycle from those same inputs.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int MAX_POSTED_DEF = 8;

  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL_CLKS = 975
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = rfsh_pkg::cnt_width(INTERVAL_CLKS);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);

  // R2: the count never leaves the period
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_tick_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
  parameter int MAX_POSTED = rfsh_pkg::MAX_POSTED_DEF,
  parameter int PEND_W     = $clog2(MAX_POSTED + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              take_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              urgent_o,
  output logic              overflow_o
);
  localparam logic [PEND_W-1:0] FULL = PEND_W'(MAX_POSTED);

  logic [PEND_W-1:0] pend_q;
  logic              ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10: begin
          if (pend_q == FULL) ovf_q  <= 1'b1;
          else                pend_q <= pend_q + PEND_W'(1);
        end
        2'b01: if (pend_q != '0) pend_q <= pend_q - PEND_W'(1);
        default: ; // idle, or a tick and a grant that cancel
      endcase
    end
  end

  assign pend_o     = pend_q;
  assign urgent_o   = (pend_q == FULL);
  assign overflow_o = ovf_q;

  p_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= FULL);
  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_take_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !tick_i) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
  p_both_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && tick_i) |=> $stable(pend_q));
endmodule

// File: rtl/rfsh_busy_timer.sv
module rfsh_busy_timer #(
  parameter int TRFC_CLKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int BW = $clog2(TRFC_CLKS + 1);
  localparam logic [BW-1:0] LOAD = BW'(TRFC_CLKS);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - BW'(1);
  end

  assign busy_o = (cnt_q != '0);

  p_busy_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == LOAD));
  p_busy_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - BW'(1)));
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int INTERVAL_CLKS = 975,
  parameter int TRFC_CLKS     = 10,
  parameter int MAX_POSTED    = rfsh_pkg::MAX_POSTED_DEF,
  parameter int PEND_W        = $clog2(MAX_POSTED + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              banks_idle_i,
  output logic              req_o,
  output logic              urgent_o,
  output logic              busy_o,
  output logic              overflow_o,
  output logic [PEND_W-1:0] pending_o
);
  logic tick;
  logic take;

  rfsh_interval_timer #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  rfsh_pending_ctr #(.MAX_POSTED(MAX_POSTED), .PEND_W(PEND_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .take_i     (take),
    .pend_o     (pending_o),
    .urgent_o   (urgent_o),
    .overflow_o (overflow_o)
  );

  rfsh_busy_timer #(.TRFC_CLKS(TRFC_CLKS)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (take),
    .busy_o  (busy_o)
  );

  assign req_o = (pending_o != '0) && !busy_o && banks_idle_i;
  assign take  = grant_i && req_o;

  p_busy_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o);
  p_ignored_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !req_o && !busy_o) |=> !busy_o);
  p_urgent_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> (pending_o != '0));
endmodule

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;
  localparam int INT  = 12;
  localparam int TRFC = 4;
  localparam int MAXP = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       grant_i = 1'b0;
  logic       banks_idle_i = 1'b0;
  logic       req_o, urgent_o, busy_o, overflow_o;
  logic [3:0] pending_o;

  always #4 clk_i = ~clk_i;

  refresh_scheduler #(.INTERVAL_CLKS(INT), .TRFC_CLKS(TRFC), .MAX_POSTED(MAXP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .grant_i(grant_i), .banks_idle_i(banks_idle_i),
    .req_o(req_o), .urgent_o(urgent_o), .busy_o(busy_o),
    .overflow_o(overflow_o), .pending_o(pending_o)
  );

  typedef struct {
    int pend;
    bit urg;
    bit ovf;
    bit req;
    bit busy;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference model state
  int mcnt = 0, mpend = 0, mbusy = 0;
  bit movf = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drives one cycle and pushes the outputs expected during it
  task automatic cyc(input bit g, input bit idle);
    bit ereq, tick, take;
    exp_t e;
    grant_i = g;
    banks_idle_i = idle;
    ereq = (mpend != 0) && (mbusy == 0) && idle;
    e.pend = mpend; e.urg = (mpend == MAXP); e.ovf = movf;
    e.req = ereq; e.busy = (mbusy != 0);
    expq.push_back(e);
    @(posedge clk_i);
    tick = (mcnt == INT - 1);
    take = g && ereq;
    mcnt = tick ? 0 : mcnt + 1;
    if (tick && !take) begin
      if (mpend == MAXP) movf = 1'b1;
      else mpend++;
    end else if (take && !tick) mpend--;
    if (take) mbusy = TRFC;
    else if (mbusy > 0) mbusy--;
    #1;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk("R2 pending_o", int'(pending_o), e.pend);
      chk("R3 urgent_o", int'(urgent_o), int'(e.urg));
      chk("R4 overflow_o", int'(overflow_o), int'(e.ovf));
      chk("R5 req_o", int'(req_o), int'(e.req));
      chk("R6 busy_o", int'(busy_o), int'(e.busy));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pending_o", int'(pending_o), 0);
    chk("R1 req_o", int'(req_o), 0);
    chk("R1 urgent_o", int'(urgent_o), 0);
    chk("R1 busy_o", int'(busy_o), 0);
    chk("R1 overflow_o", int'(overflow_o), 0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R2: three intervals with no grant
    repeat (3 * INT) cyc(1'b0, 1'b1);
    chk("R2 pending after three intervals", int'(pending_o), 3);

    // R6: accepted grant
    p0 = mpend;
    cyc(1'b1, 1'b1);
    chk("R6 pending after grant", int'(pending_o), p0 - 1);
    chk("R6 busy after grant", int'(busy_o), 1);

    // R7: grant during busy is ignored
    p0 = mpend;
    cyc(1'b1, 1'b1);
    chk("R7 pending with grant while busy", int'(pending_o), p0);
    repeat (TRFC + 1) cyc(1'b0, 1'b1);

    // R7: grant while banks not idle is ignored
    while (mcnt == INT - 1) cyc(1'b0, 1'b1);
    p0 = mpend;
    cyc(1'b1, 1'b0);
    chk("R7 pending with grant while banks busy", int'(pending_o), p0);
    chk("R7 busy with grant while banks busy", int'(busy_o), 0);

    // R8: grant on the cycle where an interval ends
    while (!(mcnt == INT - 1 && mpend != 0 && mbusy == 0)) cyc(1'b0, 1'b1);
    p0 = mpend;
    cyc(1'b1, 1'b1);
    chk("R8 pending with tick and grant", int'(pending_o), p0);
    chk("R8 busy with tick and grant", int'(busy_o), 1);

    // R3/R4: postpone until saturated and beyond
    repeat (10 * INT) cyc(1'b0, 1'b0);
    chk("R3 pending saturated", int'(pending_o), MAXP);
    chk("R3 urgent at max", int'(urgent_o), 1);
    chk("R4 overflow set", int'(overflow_o), 1);

    // drain with continuous grants, overflow stays
    repeat (8 * INT) cyc(1'b1, 1'b1);
    chk("R4 overflow sticky", int'(overflow_o), 1);
    chk("R3 urgent cleared after drain", int'(urgent_o), 0);

    cyc(1'b0, 1'b1);
    @(negedge clk_i);
    finish_run();
  end
endmodule